// File: doc/BRIEF.md
# Dual-Link Pixel Router

This block sits between a parallel pixel source and a pair of downstream serializer channels. Each input clock it receives the pixel captured on the rising edge and the pixel captured on the falling edge. Two static selects pick one of four routing schemes. A third select picks which capture edge feeds the single-edge schemes. Every scheme drives two registered output lanes, each with its own valid strobe and enable, plus a flag that tells the serializers to run at half the input rate.

In the split scheme, consecutive pixels are grouped in pairs. The pairing restarts at every rising edge of the data-enable bit, so the first active pixel of each line always lands on lane 1. The first pixel of a pair is held until its partner arrives, and both lanes then present their pixels in the same cycle. Data-enable high times and periods must be even in this scheme. A sticky error flag reports a violation until the next reset.

Top module: `dual_link_pixel_router`

## Requirements
- R1: While reset is asserted, both valid strobes, both enables, halfRate and deErr are 0.
- R2: With modeSel=1 and ddrN=1 (single), lane 1 presents the selected pixel with ch1Valid=1 one clock after capture, and ch1En=1. ch2Valid, ch2En and halfRate are all 0.
- R3: In the single-edge schemes, edgeRise=1 selects pixOnRise and edgeRise=0 selects pixOnFall.
- R4: With modeSel=0 and ddrN=1 (split), halfRate=1 and both enables are 1. Every second captured pixel completes a pair. One clock later, lane 1 shows the pair's first pixel, lane 2 shows its second pixel, and ch1Valid and ch2Valid are 1 together for that single cycle.
- R5: In the split scheme, a capture with data-enable (pixel bit 26) high that follows a capture with it low always starts a new pair, whatever the previous alignment was.
- R6: With modeSel=1 and ddrN=0 (copy), both lanes present the same selected pixel with both valids at 1 every cycle, and halfRate=0.
- R7: With modeSel=0 and ddrN=0 (both-edge), both lanes are valid every cycle. For edgeRise=1, lane 1 carries pixOnRise and lane 2 carries pixOnFall. For edgeRise=0, the two are swapped.
- R8: If pwrOn=0 or outEn=0, then one clock later both enables, both valids and halfRate are 0.
- R9: In the split scheme, a data-enable high run of odd length sets deErr in the cycle after the run ends.
- R10: In the split scheme, an odd number of captures between consecutive data-enable rises sets deErr after the second rise. Even high times and even periods leave deErr at 0.
- R11: Once set, deErr stays 1 through any change of the scheme selects, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixOnRise | input | 27 | Pixel captured on the rising edge ([23:0] colour, [24] hsync, [25] vsync, [26] data-enable) |
| pixOnFall | input | 27 | Pixel captured on the falling edge, same layout |
| modeSel | input | 1 | 1: single or copy, 0: split or both-edge |
| ddrN | input | 1 | 0 selects copy or both-edge, 1 selects single or split |
| edgeRise | input | 1 | Capture-edge select, 1 rising, 0 falling |
| pwrOn | input | 1 | 0 powers the lanes down |
| outEn | input | 1 | 0 disables the lanes |
| ch1Pix | output | 27 | Lane 1 pixel |
| ch1Valid | output | 1 | Lane 1 pixel strobe |
| ch2Pix | output | 27 | Lane 2 pixel |
| ch2Valid | output | 1 | Lane 2 pixel strobe |
| ch1En | output | 1 | Lane 1 enable |
| ch2En | output | 1 | Lane 2 enable |
| halfRate | output | 1 | Lanes run at half the input rate |
| deErr | output | 1 | Sticky data-enable parity error |

## Verification
The hardest case to reach is a pair restart that changes where a pixel lands. With even data-enable timing, the restart coincides with the natural alternation, so a design that ignored data-enable would still pass. The stimulus therefore drives an odd high run of three captures followed by two low captures. This leaves the free-running alternation out of step at the next line. Lane 1 must then show that line's first pixel one pair later, rather than a blanking pixel. The same sequence also exercises the sticky error and its survival across a scheme change.

// File: rtl/pixroute_pkg.sv
package pixroute_pkg;

  typedef enum logic [1:0] {
    RT_SINGLE   = 2'd0,
    RT_SPLIT    = 2'd1,
    RT_COPY     = 2'd2,
    RT_BOTHEDGE = 2'd3
  } routeMode_e;

  // strobes from control to datapath
  typedef struct packed {
    routeMode_e mode;
    logic       takeFall;
    logic       firstSlot;
    logic       emitPair;
    logic       linkOn;
  } routeStrobe_t;

  function automatic routeMode_e decodeMode(input logic modeSel, input logic ddrN);
    routeMode_e m;
    case ({modeSel, ddrN})
      2'b11:   m = RT_SINGLE;
      2'b01:   m = RT_SPLIT;
      2'b10:   m = RT_COPY;
      default: m = RT_BOTHEDGE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pixroute_ctrl.sv
module pixroute_ctrl
  import pixroute_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeSel,
  input  logic         ddrN,
  input  logic         edgeRise,
  input  logic         pwrOn,
  input  logic         outEn,
  input  logic         deOnRise,
  input  logic         deOnFall,
  output routeStrobe_t strobe,
  output logic         deErr
);

  routeMode_e mode;
  logic isSplit;
  logic deNow, prevDe, deUp;
  logic lastFirst, firstSlot;
  logic highOdd, periodOdd, seenRise;
  logic oddHigh, oddPeriod;

  assign mode      = decodeMode(modeSel, ddrN);
  assign isSplit   = (mode == RT_SPLIT);
  assign deNow     = edgeRise ? deOnRise : deOnFall;
  assign deUp      = deNow && !prevDe;
  assign firstSlot = deUp || !lastFirst;

  assign oddHigh   = isSplit && prevDe && !deNow && highOdd;
  assign oddPeriod = isSplit && deUp && seenRise && periodOdd;

  always_comb begin
    strobe.mode      = mode;
    strobe.takeFall  = !edgeRise;
    strobe.firstSlot = isSplit && firstSlot;
    strobe.emitPair  = isSplit && !firstSlot;
    strobe.linkOn    = pwrOn && outEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDe    <= 1'b0;
      lastFirst <= 1'b0;
      highOdd   <= 1'b0;
      periodOdd <= 1'b0;
      seenRise  <= 1'b0;
      deErr     <= 1'b0;
    end else begin
      prevDe    <= deNow;
      lastFirst <= isSplit ? firstSlot : 1'b0;
      seenRise  <= isSplit && (deUp || seenRise);
      if (deUp) begin
        highOdd   <= 1'b1;
        periodOdd <= 1'b1;
      end else begin
        if (deNow) highOdd <= !highOdd;
        periodOdd <= !periodOdd;
      end
      deErr <= deErr || oddHigh || oddPeriod;
    end
  end

  // R4
  pair_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitPair |=> !strobe.emitPair);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    deErr |=> deErr);

endmodule

// File: rtl/pixroute_data.sv
module pixroute_data
  import pixroute_pkg::*;
#(
  parameter int PIX_W = 27
)(
  input  logic             clk,
  input  logic             rstN,
  input  routeStrobe_t     strobe,
  input  logic [PIX_W-1:0] pixOnRise,
  input  logic [PIX_W-1:0] pixOnFall,
  output logic [PIX_W-1:0] ch1Pix,
  output logic             ch1Valid,
  output logic [PIX_W-1:0] ch2Pix,
  output logic             ch2Valid,
  output logic             ch1En,
  output logic             ch2En,
  output logic             halfRate
);

  localparam int LANES = 2;

  logic [PIX_W-1:0] pixSel, pixOther, holdPix;
  logic [PIX_W-1:0] pixNxt   [LANES];
  logic [PIX_W-1:0] lanePix  [LANES];
  logic             valNxt   [LANES];
  logic             laneVal  [LANES];
  logic             enNxt    [LANES];
  logic             laneEn   [LANES];
  logic             halfNxt;

  assign pixSel   = strobe.takeFall ? pixOnFall : pixOnRise;
  assign pixOther = strobe.takeFall ? pixOnRise : pixOnFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdPix <= '0;
    else if (strobe.firstSlot) holdPix <= pixSel;
  end

  always_comb begin
    pixNxt[0] = pixSel;
    pixNxt[1] = '0;
    valNxt[0] = 1'b1;
    valNxt[1] = 1'b0;
    enNxt[0]  = 1'b1;
    enNxt[1]  = 1'b0;
    halfNxt   = 1'b0;
    case (strobe.mode)
      RT_SPLIT: begin
        pixNxt[0] = holdPix;
        pixNxt[1] = pixSel;
        valNxt[0] = strobe.emitPair;
        valNxt[1] = strobe.emitPair;
        enNxt[1]  = 1'b1;
        halfNxt   = 1'b1;
      end
      RT_COPY: begin
        pixNxt[1] = pixSel;
        valNxt[1] = 1'b1;
        enNxt[1]  = 1'b1;
      end
      RT_BOTHEDGE: begin
        pixNxt[1] = pixOther;
        valNxt[1] = 1'b1;
        enNxt[1]  = 1'b1;
      end
      default: ;
    endcase
    if (!strobe.linkOn) begin
      valNxt[0] = 1'b0;
      valNxt[1] = 1'b0;
      enNxt[0]  = 1'b0;
      enNxt[1]  = 1'b0;
      halfNxt   = 1'b0;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lanePix[i] <= '0;
        laneVal[i] <= 1'b0;
        laneEn[i]  <= 1'b0;
      end else begin
        lanePix[i] <= pixNxt[i];
        laneVal[i] <= valNxt[i];
        laneEn[i]  <= enNxt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) halfRate <= 1'b0;
    else       halfRate <= halfNxt;
  end

  assign ch1Pix   = lanePix[0];
  assign ch2Pix   = lanePix[1];
  assign ch1Valid = laneVal[0];
  assign ch2Valid = laneVal[1];
  assign ch1En    = laneEn[0];
  assign ch2En    = laneEn[1];

  // R8
  link_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.linkOn |=> (!ch1Valid && !ch2Valid && !ch1En && !ch2En));

  // R2
  lane2_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    ch2Valid |-> ch2En);

  // R4
  pair_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    halfRate |-> (ch1Valid == ch2Valid));

endmodule

// File: rtl/dual_link_pixel_router.sv
module dual_link_pixel_router
  import pixroute_pkg::*;
#(
  parameter int PIX_W = 27
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixOnRise,
  input  logic [PIX_W-1:0] pixOnFall,
  input  logic             modeSel,
  input  logic             ddrN,
  input  logic             edgeRise,
  input  logic             pwrOn,
  input  logic             outEn,
  output logic [PIX_W-1:0] ch1Pix,
  output logic             ch1Valid,
  output logic [PIX_W-1:0] ch2Pix,
  output logic             ch2Valid,
  output logic             ch1En,
  output logic             ch2En,
  output logic             halfRate,
  output logic             deErr
);

  localparam int DE_BIT = PIX_W - 1;

  routeStrobe_t strobe;

  pixroute_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .ddrN     (ddrN),
    .edgeRise (edgeRise),
    .pwrOn    (pwrOn),
    .outEn    (outEn),
    .deOnRise (pixOnRise[DE_BIT]),
    .deOnFall (pixOnFall[DE_BIT]),
    .strobe   (strobe),
    .deErr    (deErr)
  );

  pixroute_data #(.PIX_W(PIX_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pixOnRise (pixOnRise),
    .pixOnFall (pixOnFall),
    .ch1Pix    (ch1Pix),
    .ch1Valid  (ch1Valid),
    .ch2Pix    (ch2Pix),
    .ch2Valid  (ch2Valid),
    .ch1En     (ch1En),
    .ch2En     (ch2En),
    .halfRate  (halfRate)
  );

endmodule

// File: tb/dual_link_pixel_router_test.sv
`timescale 1ns/1ps
module dual_link_pixel_router_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [26:0] pixOnRise = '0, pixOnFall = '0;
  logic        modeSel = 1'b1, ddrN = 1'b1, edgeRise = 1'b1, pwrOn = 1'b1, outEn = 1'b1;
  logic [26:0] ch1Pix, ch2Pix;
  logic        ch1Valid, ch2Valid, ch1En, ch2En, halfRate, deErr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_link_pixel_router uut (
    .clk(clk), .rstN(rstN), .pixOnRise(pixOnRise), .pixOnFall(pixOnFall),
    .modeSel(modeSel), .ddrN(ddrN), .edgeRise(edgeRise), .pwrOn(pwrOn), .outEn(outEn),
    .ch1Pix(ch1Pix), .ch1Valid(ch1Valid), .ch2Pix(ch2Pix), .ch2Valid(ch2Valid),
    .ch1En(ch1En), .ch2En(ch2En), .halfRate(halfRate), .deErr(deErr)
  );

  function automatic logic [26:0] px(input logic de, input logic [23:0] v);
    return {de, 2'b01, v};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one capture pair, then wait until the registered result is visible
  task automatic step(input logic [26:0] r, input logic [26:0] f);
    @(negedge clk);
    pixOnRise = r;
    pixOnFall = f;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    pixOnRise = '0;
    pixOnFall = '0;
    @(posedge clk);
    #1;
    chk("R1", "ch1Valid", {31'd0, ch1Valid}, 0);
    chk("R1", "ch2Valid", {31'd0, ch2Valid}, 0);
    chk("R1", "enables", {30'd0, ch1En, ch2En}, 0);
    chk("R1", "halfRate", {31'd0, halfRate}, 0);
    chk("R1", "deErr", {31'd0, deErr}, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setMode(input logic m, input logic d, input logic e);
    @(negedge clk);
    modeSel = m; ddrN = d; edgeRise = e;
  endtask

  task automatic tSingle();
    setMode(1, 1, 1);
    for (int i = 0; i < 3; i++) begin
      step(px(1, 24'h100 + i), px(1, 24'h900 + i));
      chk("R2", "ch1Pix", {5'd0, ch1Pix}, {5'd0, px(1, 24'h100 + i)});
      chk("R2", "ch1Valid", {31'd0, ch1Valid}, 1);
      chk("R2", "ch2Valid/ch2En/half", {29'd0, ch2Valid, ch2En, halfRate}, 0);
      chk("R2", "ch1En", {31'd0, ch1En}, 1);
    end
  endtask

  task automatic tEdge();
    setMode(1, 1, 0);
    step(px(0, 24'hAAAAAA), px(0, 24'h555555));
    chk("R3", "falling edge pick", {5'd0, ch1Pix}, {5'd0, px(0, 24'h555555)});
    setMode(1, 1, 1);
    step(px(0, 24'h123456), px(0, 24'h654321));
    chk("R3", "rising edge pick", {5'd0, ch1Pix}, {5'd0, px(0, 24'h123456)});
  endtask

  task automatic tCopy();
    setMode(1, 0, 1);
    for (int i = 0; i < 2; i++) begin
      step(px(1, 24'h200 + i), px(1, 24'h700 + i));
      chk("R6", "ch1Pix", {5'd0, ch1Pix}, {5'd0, px(1, 24'h200 + i)});
      chk("R6", "ch2Pix", {5'd0, ch2Pix}, {5'd0, px(1, 24'h200 + i)});
      chk("R6", "valids/half", {29'd0, ch1Valid, ch2Valid, halfRate}, 3'b110);
    end
  endtask

  task automatic tBothEdge();
    setMode(0, 0, 1);
    step(px(1, 24'h31), px(1, 24'h32));
    chk("R7", "ch1 rise", {5'd0, ch1Pix}, {5'd0, px(1, 24'h31)});
    chk("R7", "ch2 fall", {5'd0, ch2Pix}, {5'd0, px(1, 24'h32)});
    chk("R7", "valids", {30'd0, ch1Valid, ch2Valid}, 2'b11);
    setMode(0, 0, 0);
    step(px(1, 24'h41), px(1, 24'h42));
    chk("R7", "ch1 fall first", {5'd0, ch1Pix}, {5'd0, px(1, 24'h42)});
    chk("R7", "ch2 rise second", {5'd0, ch2Pix}, {5'd0, px(1, 24'h41)});
  endtask

  task automatic tLinkOff();
    setMode(1, 0, 1);
    @(negedge clk); pwrOn = 1'b0;
    step(px(1, 24'h5), px(1, 24'h5));
    chk("R8", "power down outs", {27'd0, ch1Valid, ch2Valid, ch1En, ch2En, halfRate}, 0);
    @(negedge clk); pwrOn = 1'b1; outEn = 1'b0;
    setMode(0, 1, 1);
    step(px(1, 24'h6), px(1, 24'h6));
    step(px(1, 24'h7), px(1, 24'h7));
    chk("R8", "output disable outs", {27'd0, ch1Valid, ch2Valid, ch1En, ch2En, halfRate}, 0);
    @(negedge clk); outEn = 1'b1;
  endtask

  task automatic tSplitEven();
    doReset();
    setMode(0, 1, 1);
    step(px(0, 0), px(0, 0));
    step(px(0, 0), px(0, 0));
    for (int ln = 0; ln < 2; ln++) begin
      step(px(1, 24'hA0 + 4*ln), 0);
      chk("R4", "no valid on first of pair", {30'd0, ch1Valid, ch2Valid}, 0);
      chk("R4", "halfRate/enables", {29'd0, halfRate, ch1En, ch2En}, 3'b111);
      step(px(1, 24'hA1 + 4*ln), 0);
      chk("R4", "pair valids", {30'd0, ch1Valid, ch2Valid}, 2'b11);
      chk("R4", "ch1 first", {5'd0, ch1Pix}, {5'd0, px(1, 24'hA0 + 4*ln)});
      chk("R4", "ch2 second", {5'd0, ch2Pix}, {5'd0, px(1, 24'hA1 + 4*ln)});
      step(px(1, 24'hA2 + 4*ln), 0);
      step(px(1, 24'hA3 + 4*ln), 0);
      chk("R4", "second pair ch1", {5'd0, ch1Pix}, {5'd0, px(1, 24'hA2 + 4*ln)});
      step(px(0, 0), 0);
      step(px(0, 0), 0);
    end
    step(px(1, 24'hB0), 0);
    chk("R10", "even timing keeps deErr clear", {31'd0, deErr}, 0);
  endtask

  task automatic tRestart();
    doReset();
    setMode(0, 1, 1);
    step(px(0, 0), 0);
    step(px(1, 24'hC0), 0);
    step(px(1, 24'hC1), 0);
    step(px(1, 24'hC2), 0);
    chk("R9", "deErr before run ends", {31'd0, deErr}, 0);
    step(px(0, 24'hD0), 0);
    chk("R9", "odd high sets deErr", {31'd0, deErr}, 1);
    step(px(0, 24'hD1), 0);
    step(px(1, 24'hE0), 0);
    chk("R5", "restart holds first pixel", {30'd0, ch1Valid, ch2Valid}, 0);
    step(px(1, 24'hE1), 0);
    chk("R5", "ch1 gets line start", {5'd0, ch1Pix}, {5'd0, px(1, 24'hE0)});
    chk("R5", "ch2 gets second", {5'd0, ch2Pix}, {5'd0, px(1, 24'hE1)});
    setMode(1, 1, 1);
    step(px(0, 0), 0);
    step(px(0, 0), 0);
    chk("R11", "deErr stays after mode change", {31'd0, deErr}, 1);
    doReset();
    chk("R11", "reset clears deErr", {31'd0, deErr}, 0);
  endtask

  task automatic tOddPeriod();
    doReset();
    setMode(0, 1, 1);
    step(px(0, 0), 0);
    step(px(1, 24'h1), 0);
    step(px(1, 24'h2), 0);
    step(px(0, 0), 0);
    step(px(0, 0), 0);
    step(px(0, 0), 0);
    chk("R10", "no error before second rise", {31'd0, deErr}, 0);
    step(px(1, 24'h3), 0);
    chk("R10", "odd period sets deErr", {31'd0, deErr}, 1);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    tSingle();
    tEdge();
    tCopy();
    tBothEdge();
    tLinkOff();
    tSplitEven();
    tRestart();
    tOddPeriod();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule